// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This unit does the arithmetic and logic for an 8-bit accumulator machine. Each operation takes the accumulator, the B register, a memory operand and the three incoming flags (carry, auxiliary carry, signed overflow). It returns a new accumulator, B and memory-operand value, together with the updated flags. Every operation has its own rule for which flags it rewrites. Flags that an operation does not touch come back out exactly as they went in.

An operation is issued by raising `start_i` with an operation code. Every operation except multiply retires on the next clock edge, so a new one can be issued every cycle. Multiply is iterative. It holds `busy_o` high for `MUL_STEPS` cycles and then writes the 16-bit product, with the high byte on the B output and the low byte on the accumulator output. `done_o` pulses for one cycle each time an operation retires. The outputs are registered and keep their values until the next retirement. A start raised while `busy_o` is high is dropped.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation retires, every data and flag output is zero and `done_o` and `busy_o` are low.
- R2: Code 0 (add) and code 1 (add with carry) return A + M + c, where c is the carry input for code 1 and 0 for code 0. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3. Overflow is set when the signed sum lies outside -128..127.
- R3: Code 2 (subtract with borrow) returns A - M - carry modulo 256. Carry is set when that difference is negative. Auxiliary carry is set when the low nibbles borrow, that is when A[3:0] - M[3:0] - carry < 0. Overflow is set when the signed difference lies outside -128..127.
- R4: Code 4 rotates A left with bit 7 going into carry and the old carry entering bit 0. Code 6 rotates A right with bit 0 going into carry and the old carry entering bit 7.
- R5: Code 3 rotates A left and code 5 rotates A right, with no carry involved. Code 7 complements A. Code 8 exchanges the two nibbles of A. None of these four changes any flag.
- R6: Code 9 swaps A[3:0] with M[3:0]. The memory-operand output carries the modified M. The upper nibbles and all flags are unchanged.
- R7: Code 11 copies M into A and changes no flag. Codes 12 to 15 return A, B and M unchanged and change no flag.
- R8: For every code except 10, `done_o` is high in the cycle after the edge that accepted the start, and `busy_o` stays low. Starts on consecutive cycles each retire.
- R9: Code 10 multiplies A by B. The product's high byte appears on `b_o` and its low byte on `acc_o`. Carry is cleared, overflow is set when the product exceeds 255, and auxiliary carry and M pass through unchanged.
- R10: After a multiply is accepted, `busy_o` is high and `done_o` is low for `MUL_STEPS` cycles. The result and `done_o` appear after the `MUL_STEPS`-th following edge, in the same cycle that `busy_o` falls.
- R11: A start sampled while `busy_o` is high is ignored. This includes a start at the edge where the multiply retires: no further `done_o` follows it, and the outputs keep the multiply result.
- R12: Outputs change only in a cycle in which `done_o` is high. Between retirements they hold their values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Issue the operation on `op_i` |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| b_i | input | 8 | B register operand |
| mem_i | input | 8 | Memory operand |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| busy_o | output | 1 | Multiply in progress; starts are ignored |
| done_o | output | 1 | One-cycle pulse when an operation retires |
| acc_o | output | 8 | Accumulator result |
| b_o | output | 8 | B result (product high byte after multiply) |
| mem_o | output | 8 | Memory-operand result |
| cy_o | output | 1 | Carry flag result |
| ac_o | output | 1 | Auxiliary carry flag result |
| ov_o | output | 1 | Overflow flag result |

## Verification
Two events can fall on the same clock edge: a multiply retiring, and a new start arriving that would otherwise be accepted as a single-cycle operation. The bench provokes this by raising `start_i` with an add operation and unrelated operands at the edge where the multiply retires, and also at an earlier edge inside the busy window. The result is judged correct when the product and multiply flags appear intact with a single `done_o` pulse, and when the following idle cycle shows `done_o` low and every output unchanged. As a contrast, an operation issued on the cycle right after a retirement must be accepted.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_RL   = 4'd3,
    OP_RLC  = 4'd4,
    OP_RR   = 4'd5,
    OP_RRC  = 4'd6,
    OP_CPL  = 4'd7,
    OP_SWAP = 4'd8,
    OP_XCHD = 4'd9,
    OP_MUL  = 4'd10,
    OP_MOV  = 4'd11
  } op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int H = W / 2;

  logic [W-1:0] bx;
  logic         ci;
  logic [H:0]   lo_sum;
  logic [W-1:0] hi7_sum;
  logic [W:0]   full_sum;

  // subtraction as a + ~b + ~borrow; carries are inverted back into borrows
  always_comb begin
    bx       = sub_i ? ~b_i : b_i;
    ci       = sub_i ? ~cin_i : cin_i;
    lo_sum   = {1'b0, a_i[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, ci};
    hi7_sum  = {1'b0, a_i[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, ci};
    full_sum = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, ci};
    res_o    = full_sum[W-1:0];
    cy_o     = full_sum[W] ^ sub_i;
    ac_o     = lo_sum[H] ^ sub_i;
    ov_o     = full_sum[W] ^ hi7_sum[W-1];
  end

endmodule

// File: rtl/alu_unary.sv
module alu_unary
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] mem_o,
  output logic         cy_o
);
  localparam int H = W / 2;

  always_comb begin
    res_o = a_i;
    mem_o = m_i;
    cy_o  = cin_i;
    case (op_i)
      OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
      OP_RLC:  begin
                 res_o = {a_i[W-2:0], cin_i};
                 cy_o  = a_i[W-1];
               end
      OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
      OP_RRC:  begin
                 res_o = {cin_i, a_i[W-1:1]};
                 cy_o  = a_i[0];
               end
      OP_CPL:  res_o = ~a_i;
      OP_SWAP: res_o = {a_i[H-1:0], a_i[W-1:H]};
      OP_XCHD: begin
                 res_o = {a_i[W-1:H], m_i[H-1:0]};
                 mem_o = {m_i[W-1:H], a_i[H-1:0]};
               end
      OP_MOV:  res_o = m_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int W     = 8,
  parameter int STEPS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           busy_o,
  output logic           fin_o,
  output logic [2*W-1:0] prod_o
);
  localparam int BPS = W / STEPS;
  localparam int CW  = $clog2(STEPS + 1);
  localparam int PW  = 2 * W;

  logic [PW-1:0] mcand_q, mcand_d;
  logic [W-1:0]  mplier_q, mplier_d;
  logic [PW-1:0] prod_q, prod_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [PW-1:0] part;
  logic [PW-1:0] sum;
  logic          last;

  // BPS multiplier bits retired per cycle
  always_comb begin
    part = '0;
    for (int i = 0; i < BPS; i++) begin
      if (mplier_q[i]) part = part + (mcand_q << i);
    end
    sum  = prod_q + part;
    last = busy_q && (cnt_q == CW'(STEPS - 1));
  end

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    prod_d   = prod_q;
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    if (go_i) begin
      mcand_d  = {{W{1'b0}}, a_i};
      mplier_d = b_i;
      prod_d   = '0;
      cnt_d    = '0;
      busy_d   = 1'b1;
    end else if (busy_q) begin
      mcand_d  = mcand_q << BPS;
      mplier_d = mplier_q >> BPS;
      prod_d   = sum;
      cnt_d    = CW'(cnt_q + 1'b1);
      busy_d   = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
    end else begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      prod_q   <= prod_d;
      cnt_q    <= cnt_d;
      busy_q   <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = last;
  assign prod_o = sum;

  AST_MUL_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(STEPS))); // R10
  AST_MUL_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q); // R11
  AST_MUL_FIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !busy_q); // R10

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import accalu_pkg::*;
#(
  parameter int W         = 8,
  parameter int MUL_STEPS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] mem_i,
  input  logic         cy_i,
  input  logic         ac_i,
  input  logic         ov_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] mem_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);
  op_e op;
  assign op = op_e'(op_i);

  logic accept, go_mul, go_one, is_arith;
  logic mul_busy, mul_fin;
  logic [2*W-1:0] prod;

  logic [W-1:0] as_res;
  logic         as_cy, as_ac, as_ov, as_cin, as_sub;
  logic [W-1:0] un_res, un_mem;
  logic         un_cy;

  logic [W-1:0] acc_q, acc_d, b_q, b_d, mem_q, mem_d;
  flags_t       fl_q, fl_d;
  logic         done_q, done_d;
  logic [W-1:0] mhold_q;
  logic         achold_q;

  assign accept   = start_i && !mul_busy;
  assign go_mul   = accept && (op == OP_MUL);
  assign go_one   = accept && (op != OP_MUL);
  assign is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
  assign as_cin   = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_i : 1'b0;
  assign as_sub   = (op == OP_SUBB);

  alu_addsub #(.W(W)) i_addsub (
    .a_i(acc_i), .b_i(mem_i), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  alu_unary #(.W(W)) i_unary (
    .op_i(op), .a_i(acc_i), .m_i(mem_i), .cin_i(cy_i),
    .res_o(un_res), .mem_o(un_mem), .cy_o(un_cy)
  );

  alu_mul #(.W(W), .STEPS(MUL_STEPS)) i_mul (
    .clk(clk), .rst_n(rst_n), .go_i(go_mul), .a_i(acc_i), .b_i(b_i),
    .busy_o(mul_busy), .fin_o(mul_fin), .prod_o(prod)
  );

  // next state of the result registers: single-cycle retire, multiply retire, or hold
  always_comb begin
    acc_d  = acc_q;
    b_d    = b_q;
    mem_d  = mem_q;
    fl_d   = fl_q;
    done_d = 1'b0;
    if (go_one) begin
      done_d = 1'b1;
      b_d    = b_i;
      if (is_arith) begin
        acc_d = as_res;
        mem_d = mem_i;
        fl_d  = '{cy: as_cy, ac: as_ac, ov: as_ov};
      end else begin
        acc_d = un_res;
        mem_d = un_mem;
        fl_d  = '{cy: un_cy, ac: ac_i, ov: ov_i};
      end
    end else if (mul_fin) begin
      done_d = 1'b1;
      acc_d  = prod[W-1:0];
      b_d    = prod[2*W-1:W];
      mem_d  = mhold_q;
      fl_d   = '{cy: 1'b0, ac: achold_q, ov: |prod[2*W-1:W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      b_q      <= '0;
      mem_q    <= '0;
      fl_q     <= '0;
      done_q   <= 1'b0;
      mhold_q  <= '0;
      achold_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      b_q    <= b_d;
      mem_q  <= mem_d;
      fl_q   <= fl_d;
      done_q <= done_d;
      if (go_mul) begin
        mhold_q  <= mem_i;
        achold_q <= ac_i;
      end
    end
  end

  assign busy_o = mul_busy;
  assign done_o = done_q;
  assign acc_o  = acc_q;
  assign b_o    = b_q;
  assign mem_o  = mem_q;
  assign cy_o   = fl_q.cy;
  assign ac_o   = fl_q.ac;
  assign ov_o   = fl_q.ov;

  AST_ADD_OV_SIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    (go_one && is_arith && !as_sub && as_ov) |-> (acc_i[W-1] == mem_i[W-1])); // R2
  AST_SUB_OV_SIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    (go_one && as_sub && as_ov) |-> (acc_i[W-1] != mem_i[W-1])); // R3
  AST_ONE_CYCLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (op_i != 4'(OP_MUL))) |=> (done_o && !busy_o)); // R8
  AST_MUL_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (op_i == 4'(OP_MUL))) |=> (busy_o && !done_o)); // R10
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o); // R10
  AST_MUL_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(busy_o)) |-> !cy_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({acc_o, b_o, mem_o, cy_o, ac_o, ov_o})); // R12

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [3:0] op_i;
  logic [7:0] acc_i, b_i, mem_i;
  logic       cy_i, ac_i, ov_i;
  logic       busy_o, done_o;
  logic [7:0] acc_o, b_o, mem_o;
  logic       cy_o, ac_o, ov_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  logic [7:0] h_acc, h_b, h_m;
  logic       h_cy, h_ac, h_ov;

  acc_alu #(.W(8), .MUL_STEPS(4)) i_acc_alu (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .acc_i(acc_i), .b_i(b_i), .mem_i(mem_i),
    .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
    .busy_o(busy_o), .done_o(done_o),
    .acc_o(acc_o), .b_o(b_o), .mem_o(mem_o),
    .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_err++;
      $display("FAIL R10 watchdog expired act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic model(input logic [3:0] op, input logic [7:0] a, b, m,
                       input logic cy, ac, ov);
    int ai, bi, mi, ci, sa, sm, s, sv;
    ai = int'(a); bi = int'(b); mi = int'(m); ci = int'(cy);
    sa = (ai > 127) ? ai - 256 : ai;
    sm = (mi > 127) ? mi - 256 : mi;
    h_acc = a; h_b = b; h_m = m; h_cy = cy; h_ac = ac; h_ov = ov;
    case (op)
      4'd0, 4'd1: begin
        if (op == 4'd0) ci = 0;
        s     = ai + mi + ci;
        h_acc = 8'(s);
        h_cy  = (s > 255);
        h_ac  = ((ai % 16) + (mi % 16) + ci) > 15;
        sv    = sa + sm + ci;
        h_ov  = (sv > 127) || (sv < -128);
      end
      4'd2: begin
        s     = ai - mi - ci;
        h_acc = 8'(s);
        h_cy  = (s < 0);
        h_ac  = ((ai % 16) - (mi % 16) - ci) < 0;
        sv    = sa - sm - ci;
        h_ov  = (sv > 127) || (sv < -128);
      end
      4'd3: h_acc = 8'((ai * 2 + ai / 128) % 256);
      4'd4: begin h_acc = 8'((ai * 2 + ci) % 256); h_cy = (ai >= 128); end
      4'd5: h_acc = 8'(ai / 2 + (ai % 2) * 128);
      4'd6: begin h_acc = 8'(ai / 2 + ci * 128); h_cy = (ai % 2) == 1; end
      4'd7: h_acc = 8'(255 - ai);
      4'd8: h_acc = 8'((ai % 16) * 16 + ai / 16);
      4'd9: begin
        h_acc = 8'((ai / 16) * 16 + mi % 16);
        h_m   = 8'((mi / 16) * 16 + ai % 16);
      end
      4'd10: begin
        s     = ai * bi;
        h_acc = 8'(s % 256);
        h_b   = 8'(s / 256);
        h_cy  = 1'b0;
        h_ov  = (s > 255);
      end
      4'd11: h_acc = m;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic edone, input logic ebusy);
    n_chk++;
    if ({acc_o, b_o, mem_o, cy_o, ac_o, ov_o, done_o, busy_o} !==
        {h_acc, h_b, h_m, h_cy, h_ac, h_ov, edone, ebusy}) begin
      n_err++;
      $display("FAIL %s act acc=%h b=%h m=%h cy=%b ac=%b ov=%b done=%b busy=%b exp acc=%h b=%h m=%h cy=%b ac=%b ov=%b done=%b busy=%b",
               req, acc_o, b_o, mem_o, cy_o, ac_o, ov_o, done_o, busy_o,
               h_acc, h_b, h_m, h_cy, h_ac, h_ov, edone, ebusy);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a, b, m,
                       input logic cy, ac, ov);
    start_i = 1'b1; op_i = op; acc_i = a; b_i = b; mem_i = m;
    cy_i = cy; ac_i = ac; ov_i = ov;
  endtask

  task automatic run_one(input logic [3:0] op, input logic [7:0] a, b, m,
                         input logic cy, ac, ov, input string req);
    model(op, a, b, m, cy, ac, ov);
    drive(op, a, b, m, cy, ac, ov);
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    check(req, 1'b1, 1'b0);
  endtask

  task automatic idle(input logic [7:0] junk);
    start_i = 1'b0; op_i = junk[3:0]; acc_i = ~junk; b_i = junk; mem_i = junk ^ 8'h5a;
    cy_i = junk[0]; ac_i = junk[1]; ov_i = junk[2];
    @(posedge clk); @(negedge clk);
    check("R12 idle hold", 1'b0, 1'b0);
  endtask

  // collide: 0 none, k in 1..4 raises an add start before edge k of the busy window
  task automatic run_mul(input logic [7:0] a, b, m, input logic cy, ac, ov,
                         input int collide);
    drive(4'd10, a, b, m, cy, ac, ov);
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      check("R10 multiply busy window", 1'b0, 1'b1);
      if (collide == k) drive(4'd0, 8'h7f, 8'h11, 8'h01, 1'b1, 1'b0, 1'b1);
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
    end
    model(4'd10, a, b, m, cy, ac, ov);
    check("R9 multiply result", 1'b1, 1'b0);
    if (collide != 0) begin
      @(posedge clk); @(negedge clk);
      check("R11 start during busy ignored", 1'b0, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0; op_i = 4'd0; acc_i = 8'h00; b_i = 8'h00; mem_i = 8'h00;
    cy_i = 1'b0; ac_i = 1'b0; ov_i = 1'b0;
    h_acc = 8'h00; h_b = 8'h00; h_m = 8'h00; h_cy = 1'b0; h_ac = 1'b0; h_ov = 1'b0;
    drive(4'd1, 8'hff, 8'hff, 8'hff, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 1'b0);

    // R2 / R3 arithmetic sweeps, issued back to back (R8)
    for (int op = 0; op < 3; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int m = 0; m < 256; m += 5)
            run_one(4'(op), 8'(a), 8'(a ^ m), 8'(m), 1'(c), 1'(a), 1'(m >> 1),
                    (op == 2) ? "R3 subtract with borrow" : "R2 add / add with carry");
    idle(8'h3c);

    // R4 R5 R6 R7 over every accumulator value and both carries
    for (int op = 3; op < 16; op++) begin
      if (op == 10) continue;
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          run_one(4'(op), 8'(a), 8'(a + 3), 8'((a * 37 + 11) % 256), 1'(c),
                  1'(a >> 2), 1'(a >> 5),
                  (op == 4 || op == 6) ? "R4 rotate through carry" :
                  (op == 9) ? "R6 low nibble exchange" :
                  (op >= 11) ? "R7 move / unused code" : "R5 flag-preserving op");
    end
    idle(8'ha7);

    // R9 / R10 multiply corners, then R11 collisions
    run_mul(8'hff, 8'hff, 8'h12, 1'b1, 1'b1, 1'b0, 0);
    run_mul(8'h10, 8'h10, 8'h34, 1'b1, 1'b0, 1'b0, 0);
    run_mul(8'h0f, 8'h11, 8'h56, 1'b1, 1'b1, 1'b1, 0);
    run_mul(8'h00, 8'h9d, 8'h78, 1'b0, 1'b0, 1'b1, 0);
    run_mul(8'hc3, 8'h5a, 8'h9a, 1'b1, 1'b1, 1'b0, 4);
    run_mul(8'h2b, 8'he1, 8'hbc, 1'b0, 1'b0, 1'b0, 1);
    run_mul(8'h80, 8'h02, 8'hde, 1'b1, 1'b0, 1'b1, 2);
    // R8 single-cycle op accepted right after a multiply retires
    run_mul(8'h07, 8'h09, 8'h01, 1'b0, 1'b1, 1'b0, 0);
    run_one(4'd2, 8'h80, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, "R8 op after multiply");
    idle(8'h11);

    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        run_mul(8'(a), 8'(b), 8'(a + b), 1'(b), 1'(a), 1'(a >> 1), 0);
    idle(8'h66);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule